// File: doc/BRIEF.md
# Framebuffer Scan-Out Display Controller

This block reads a 640x480 true-colour picture out of memory and streams it to a TFT or VGA style pixel output. It keeps its own line and frame counters. For every visible pixel it issues one word read to a simple request/data memory port. It splits each returned 32-bit word into 8-bit red, green and blue outputs. Horizontal and vertical sync and a data-enable strobe travel with the pixels, aligned to them.

Software programs the block through two write/read registers on a byte-addressed port. The frame-base register sits at byte offset 0 and the control register at byte offset 4. Control bit 0 turns the display on and bit 1 turns the picture by 180 degrees. Each picture row takes 1024 words of memory, and only the first 640 of them are fetched. With rotation on, the whole fetch order is reversed. A new base address or rotate setting takes effect only at the next frame boundary, while the enable bit acts on the very next cycle. Memory data must come back a fixed number of cycles (`RD_LAT`) after each request.

Top module: `fb_scanout`

## Requirements
- R1: While reset is asserted and after it is released, both registers read zero. With the display still off, no read is requested, data-enable is low, colour is zero and both sync outputs are high.
- R2: A write to byte offset 0 stores only bits 31:21 of the data as the frame base. Reading offset 0 returns those bits with bits 20:0 as zero.
- R3: A write to byte offset 4 stores bit 0 as enable and bit 1 as rotate. Reading offset 4 returns them in bits 1:0 with all other bits zero. Writes to any other offset change neither register.
- R4: A line is 800 cycles long: 640 visible, then 16 front porch, 96 sync and 48 back porch. A frame is 525 lines long: 480 visible, then 10 front porch, 2 sync and 33 back porch. `hsync_n` and `vsync_n` are low only in their sync windows. The outputs lag the counters by `RD_LAT`+1 cycles.
- R5: `pix_de` is high only for visible pixels fetched while the display was enabled. It is aligned with the colour returned for that pixel.
- R6: With rotate off, the pixel in row r and column c is read from byte address base + 4*(1024*r + c). Exactly one request is made per visible pixel and none outside the visible area.
- R7: With rotate on, the pixel in row r and column c is read from base + 4*(1024*(479-r) + (639-c)). The first pixel of a frame therefore comes from row 479, column 639.
- R8: Returned data bits 23:16, 15:8 and 7:0 drive `pix_r`, `pix_g` and `pix_b`. Bits 31:24 are ignored. Data is taken exactly `RD_LAT` cycles after its request.
- R9: When enable is cleared, requests stop from the next cycle, `pix_de` drops and colour becomes zero. The syncs keep running.
- R10: The base and rotate values used for fetching are copied from the registers only in the last cycle of a frame, so each frame uses one setting throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| mem_req | output | 1 | Word read request |
| mem_addr | output | 32 | Byte address of requested word |
| mem_rdata | input | 32 | Read data, valid `RD_LAT` cycles after request |
| pix_r | output | 8 | Red level |
| pix_g | output | 8 | Green level |
| pix_b | output | 8 | Blue level |
| pix_de | output | 1 | High for a displayed pixel |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |

## Verification
The bench makes mid-frame writes to base and rotate, so a design that applies them at once would show a torn frame: addresses would change inside a frame and the cycle-by-cycle model would flag them. Writes to the enable bit are also placed inside the visible area, which catches a design whose blanking lags by one cycle or leaves stale colour on the outputs. Memory words carry a nonzero top byte and contents that vary with the address, so a wrong byte order, a leaked top byte, or a latency that is off by one shows up as a colour mismatch. Rotated frames check both end-of-range corners, row and column at zero and at their last value, where a reversed index tends to be off by one.

// File: rtl/fbs_pkg.sv
package fbs_pkg;

  typedef struct packed {
    logic vis;
    logic hs;
    logic vs;
  } fbs_tim_t;

  // Byte address of one picture element; rotation mirrors both axes.
  function automatic logic [31:0] fbs_pix_addr(
    input logic [31:0] base,
    input logic [31:0] col,
    input logic [31:0] row,
    input logic [31:0] stride,
    input logic [31:0] h_act,
    input logic [31:0] v_act,
    input logic        rot
  );
    logic [31:0] c;
    logic [31:0] r;
    c = rot ? (h_act - 32'd1 - col) : col;
    r = rot ? (v_act - 32'd1 - row) : row;
    return base + ((r * stride + c) << 2);
  endfunction

  function automatic logic in_window(
    input logic [31:0] cnt,
    input logic [31:0] start,
    input logic [31:0] len
  );
    return (cnt >= start) && (cnt < start + len);
  endfunction

endpackage

// File: rtl/fbs_regs.sv
module fbs_regs #(
  parameter int unsigned BASE_KEEP = 11
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wen,
  input  logic [3:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  input  logic        frame_end,
  output logic        en,
  output logic [31:0] act_base,
  output logic        act_rot
);
  localparam int unsigned LOW_BITS = 32 - BASE_KEEP;
  localparam logic [31:0] BASE_MASK = ~((32'd1 << LOW_BITS) - 32'd1);
  localparam logic [3:0] OFS_BASE = 4'd0;
  localparam logic [3:0] OFS_CTRL = 4'd4;

  logic [31:0] base_q;
  logic        en_q;
  logic        rot_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      en_q   <= 1'b0;
      rot_q  <= 1'b0;
    end else if (wen) begin
      if (addr == OFS_BASE) base_q <= wdata & BASE_MASK;
      if (addr == OFS_CTRL) begin
        en_q  <= wdata[0];
        rot_q <= wdata[1];
      end
    end
  end

  // Frame-wide copies, refreshed only at the frame boundary.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_base <= '0;
      act_rot  <= 1'b0;
    end else if (frame_end) begin
      act_base <= base_q;
      act_rot  <= rot_q;
    end
  end

  always_comb begin
    case (addr)
      OFS_BASE: rdata = base_q;
      OFS_CTRL: rdata = {30'd0, rot_q, en_q};
      default:  rdata = '0;
    endcase
  end

  assign en = en_q;

endmodule

// File: rtl/fbs_timing.sv
module fbs_timing #(
  parameter int unsigned H_ACTIVE = 640,
  parameter int unsigned H_FRONT  = 16,
  parameter int unsigned H_SYNC   = 96,
  parameter int unsigned H_BACK   = 48,
  parameter int unsigned V_ACTIVE = 480,
  parameter int unsigned V_FRONT  = 10,
  parameter int unsigned V_SYNC   = 2,
  parameter int unsigned V_BACK   = 33,
  parameter int unsigned HW       = 10,
  parameter int unsigned VW       = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [HW-1:0] hcnt,
  output logic [VW-1:0] vcnt,
  output logic          vis,
  output logic          hs,
  output logic          vs,
  output logic          frame_end
);
  import fbs_pkg::*;

  localparam int unsigned H_TOTAL = H_ACTIVE + H_FRONT + H_SYNC + H_BACK;
  localparam int unsigned V_TOTAL = V_ACTIVE + V_FRONT + V_SYNC + V_BACK;
  localparam logic [HW-1:0] H_LAST = HW'(H_TOTAL - 1);
  localparam logic [VW-1:0] V_LAST = VW'(V_TOTAL - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt <= '0;
      vcnt <= '0;
    end else if (hcnt == H_LAST) begin
      hcnt <= '0;
      vcnt <= (vcnt == V_LAST) ? '0 : vcnt + 1'b1;
    end else begin
      hcnt <= hcnt + 1'b1;
    end
  end

  assign vis       = (32'(hcnt) < H_ACTIVE) && (32'(vcnt) < V_ACTIVE);
  assign hs        = in_window(32'(hcnt), H_ACTIVE + H_FRONT, H_SYNC);
  assign vs        = in_window(32'(vcnt), V_ACTIVE + V_FRONT, V_SYNC);
  assign frame_end = (hcnt == H_LAST) && (vcnt == V_LAST);

endmodule

// File: rtl/fbs_fetch.sv
module fbs_fetch #(
  parameter int unsigned H_ACTIVE  = 640,
  parameter int unsigned V_ACTIVE  = 480,
  parameter int unsigned ROW_WORDS = 1024,
  parameter int unsigned HW        = 10,
  parameter int unsigned VW        = 10
) (
  input  logic [HW-1:0] hcnt,
  input  logic [VW-1:0] vcnt,
  input  logic          vis,
  input  logic          en,
  input  logic [31:0]   base,
  input  logic          rot,
  output logic          req,
  output logic [31:0]   addr
);
  import fbs_pkg::*;

  assign req  = vis && en;
  assign addr = fbs_pix_addr(base, 32'(hcnt), 32'(vcnt), 32'(ROW_WORDS),
                             32'(H_ACTIVE), 32'(V_ACTIVE), rot);

endmodule

// File: rtl/fbs_pixout.sv
module fbs_pixout #(
  parameter int unsigned RD_LAT = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        fetch,
  input  logic        hs,
  input  logic        vs,
  input  logic        en,
  input  logic [31:0] rdata,
  output logic        de,
  output logic [7:0]  red,
  output logic [7:0]  grn,
  output logic [7:0]  blu,
  output logic        hsync_n,
  output logic        vsync_n
);
  import fbs_pkg::*;

  fbs_tim_t st [RD_LAT];
  logic     show;
  logic     unused_top;

  assign unused_top = ^rdata[31:24];
  assign show       = st[RD_LAT-1].vis && en;

  // Timing rides a delay line matching the memory latency.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < RD_LAT; i++) st[i] <= '0;
    end else begin
      st[0] <= '{vis: fetch, hs: hs, vs: vs};
      for (int i = 1; i < RD_LAT; i++) st[i] <= st[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      de      <= 1'b0;
      red     <= '0;
      grn     <= '0;
      blu     <= '0;
      hsync_n <= 1'b1;
      vsync_n <= 1'b1;
    end else begin
      de      <= show;
      red     <= show ? rdata[23:16] : 8'd0;
      grn     <= show ? rdata[15:8]  : 8'd0;
      blu     <= show ? rdata[7:0]   : 8'd0;
      hsync_n <= ~st[RD_LAT-1].hs;
      vsync_n <= ~st[RD_LAT-1].vs;
    end
  end

endmodule

// File: rtl/fb_scanout.sv
module fb_scanout #(
  parameter int unsigned H_ACTIVE  = 640,
  parameter int unsigned H_FRONT   = 16,
  parameter int unsigned H_SYNC    = 96,
  parameter int unsigned H_BACK    = 48,
  parameter int unsigned V_ACTIVE  = 480,
  parameter int unsigned V_FRONT   = 10,
  parameter int unsigned V_SYNC    = 2,
  parameter int unsigned V_BACK    = 33,
  parameter int unsigned ROW_WORDS = 1024,
  parameter int unsigned BASE_KEEP = 11,
  parameter int unsigned RD_LAT    = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wen,
  input  logic [3:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mem_req,
  output logic [31:0] mem_addr,
  input  logic [31:0] mem_rdata,
  output logic [7:0]  pix_r,
  output logic [7:0]  pix_g,
  output logic [7:0]  pix_b,
  output logic        pix_de,
  output logic        hsync_n,
  output logic        vsync_n
);
  localparam int unsigned H_TOTAL = H_ACTIVE + H_FRONT + H_SYNC + H_BACK;
  localparam int unsigned V_TOTAL = V_ACTIVE + V_FRONT + V_SYNC + V_BACK;
  localparam int unsigned HW = $clog2(H_TOTAL);
  localparam int unsigned VW = $clog2(V_TOTAL);

  logic [HW-1:0] hcnt;
  logic [VW-1:0] vcnt;
  logic          vis_raw;
  logic          hs_raw;
  logic          vs_raw;
  logic          frame_end;
  logic          ctrl_en;
  logic [31:0]   act_base;
  logic          act_rot;

  fbs_regs #(.BASE_KEEP(BASE_KEEP)) u_regs (
    .clk(clk), .rst_n(rst_n), .wen(reg_wen), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .frame_end(frame_end),
    .en(ctrl_en), .act_base(act_base), .act_rot(act_rot)
  );

  fbs_timing #(
    .H_ACTIVE(H_ACTIVE), .H_FRONT(H_FRONT), .H_SYNC(H_SYNC), .H_BACK(H_BACK),
    .V_ACTIVE(V_ACTIVE), .V_FRONT(V_FRONT), .V_SYNC(V_SYNC), .V_BACK(V_BACK),
    .HW(HW), .VW(VW)
  ) u_timing (
    .clk(clk), .rst_n(rst_n), .hcnt(hcnt), .vcnt(vcnt), .vis(vis_raw),
    .hs(hs_raw), .vs(vs_raw), .frame_end(frame_end)
  );

  fbs_fetch #(
    .H_ACTIVE(H_ACTIVE), .V_ACTIVE(V_ACTIVE), .ROW_WORDS(ROW_WORDS),
    .HW(HW), .VW(VW)
  ) u_fetch (
    .hcnt(hcnt), .vcnt(vcnt), .vis(vis_raw), .en(ctrl_en),
    .base(act_base), .rot(act_rot), .req(mem_req), .addr(mem_addr)
  );

  fbs_pixout #(.RD_LAT(RD_LAT)) u_pix (
    .clk(clk), .rst_n(rst_n), .fetch(mem_req), .hs(hs_raw), .vs(vs_raw),
    .en(ctrl_en), .rdata(mem_rdata), .de(pix_de), .red(pix_r),
    .grn(pix_g), .blu(pix_b), .hsync_n(hsync_n), .vsync_n(vsync_n)
  );

endmodule

// File: rtl/fbs_chk.sv
module fbs_chk #(
  parameter int unsigned BASE_KEEP = 11
) (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_req,
  input logic [31:0] mem_addr,
  input logic        ctrl_en,
  input logic [31:0] act_base,
  input logic        frame_end,
  input logic        pix_de,
  input logic [7:0]  pix_r,
  input logic [7:0]  pix_g,
  input logic [7:0]  pix_b,
  input logic        hsync_n,
  input logic        vsync_n,
  input logic [3:0]  reg_addr,
  input logic [31:0] reg_rdata
);
  localparam int unsigned LOW_BITS = 32 - BASE_KEEP;

  // R9
  fetch_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> ctrl_en);

  // R9
  blank_black_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_de |-> ({pix_r, pix_g, pix_b} == 24'd0));

  // R10
  base_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> $stable(act_base));

  // R6
  fetch_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[31:LOW_BITS] == act_base[31:LOW_BITS])
                && (mem_addr[1:0] == 2'b00));

  // R5
  de_not_in_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_de |-> (hsync_n && vsync_n));

  // R2
  base_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 4'd0) |-> (reg_rdata[LOW_BITS-1:0] == '0));

endmodule

bind fb_scanout fbs_chk #(.BASE_KEEP(BASE_KEEP)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_addr(mem_addr),
  .ctrl_en(ctrl_en), .act_base(act_base), .frame_end(frame_end),
  .pix_de(pix_de), .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b),
  .hsync_n(hsync_n), .vsync_n(vsync_n), .reg_addr(reg_addr),
  .reg_rdata(reg_rdata)
);

// File: tb/sim_fb_scanout.sv
module sim_fb_scanout;
  localparam int CLK_PERIOD = 10;
  localparam int HA = 8, HFP = 2, HSW = 3, HBP = 2;
  localparam int VA = 4, VFP = 1, VSW = 1, VBP = 2;
  localparam int HT = HA + HFP + HSW + HBP;
  localparam int VT = VA + VFP + VSW + VBP;
  localparam int FRAME = HT * VT;
  localparam int STRIDE = 16;
  localparam int KEEP = 11;
  localparam int LAT = 2;
  localparam logic [31:0] MASK = 32'hFFE0_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wen = 1'b0;
  logic [3:0] reg_addr = 4'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic mem_req;
  logic [31:0] mem_addr;
  logic [31:0] mem_rdata;
  logic [7:0] pix_r, pix_g, pix_b;
  logic pix_de, hsync_n, vsync_n;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fb_scanout #(
    .H_ACTIVE(HA), .H_FRONT(HFP), .H_SYNC(HSW), .H_BACK(HBP),
    .V_ACTIVE(VA), .V_FRONT(VFP), .V_SYNC(VSW), .V_BACK(VBP),
    .ROW_WORDS(STRIDE), .BASE_KEEP(KEEP), .RD_LAT(LAT)
  ) u0 (.*);

  // Memory contents vary with address; top byte is junk that must be dropped.
  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return {8'hC3, a[21:14] ^ 8'h11, a[13:6], a[9:2] ^ 8'h80};
  endfunction

  // Fixed-latency memory model.
  logic [31:0] mpipe [LAT];
  always @(posedge clk) begin
    mpipe[0] <= mem_word(mem_addr);
    for (int i = 1; i < LAT; i++) mpipe[i] <= mpipe[i-1];
  end
  assign mem_rdata = mpipe[LAT-1];

  // Behavioural reference model.
  typedef struct { bit req; bit hs; bit vs; logic [31:0] addr; } slot_t;
  slot_t q[$];
  int mh, mv;
  logic [31:0] m_base, s_base;
  bit m_en, m_rot, s_rot;
  bit o_de, o_hs, o_vs;
  logic [23:0] o_rgb;

  function automatic logic [31:0] exp_addr(input int h, input int v,
                                           input bit rot, input logic [31:0] b);
    int c, r;
    c = rot ? (HA - 1 - h) : h;
    r = rot ? (VA - 1 - v) : v;
    return b + 32'((r * STRIDE + c) * 4);
  endfunction

  function automatic slot_t cur_slot();
    slot_t s;
    s.req  = (mh < HA) && (mv < VA) && m_en;
    s.hs   = (mh >= HA + HFP) && (mh < HA + HFP + HSW);
    s.vs   = (mv >= VA + VFP) && (mv < VA + VFP + VSW);
    s.addr = exp_addr(mh, mv, s_rot, s_base);
    return s;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mh = 0; mv = 0; m_base = '0; s_base = '0;
      m_en = 0; m_rot = 0; s_rot = 0;
      o_de = 0; o_hs = 0; o_vs = 0; o_rgb = '0;
      q.delete();
      for (int i = 0; i < LAT; i++) q.push_back('{0, 0, 0, 32'd0});
    end else begin
      slot_t cur, old;
      cur = cur_slot();
      old = q.pop_front();
      o_de  = old.req && m_en;
      o_rgb = o_de ? mem_word(old.addr) : 24'd0;
      o_hs  = old.hs;
      o_vs  = old.vs;
      q.push_back(cur);
      if (mh == HT - 1 && mv == VT - 1) begin
        s_base = m_base;
        s_rot  = m_rot;
      end
      if (reg_wen && reg_addr == 4'd0) m_base = reg_wdata & MASK;
      if (reg_wen && reg_addr == 4'd4) begin
        m_en  = reg_wdata[0];
        m_rot = reg_wdata[1];
      end
      if (mh == HT - 1) begin
        mh = 0;
        mv = (mv == VT - 1) ? 0 : mv + 1;
      end else mh = mh + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h (h=%0d v=%0d t=%0t)",
               tag, act, exp, mh, mv, $time);
    end
  endtask

  // Per-cycle comparison away from the active edge.
  always @(negedge clk) begin
    if (rst_n) begin
      slot_t s;
      s = cur_slot();
      chk(mem_req == s.req, s.req ? "R6 fetch" : "R9 fetch", 32'(mem_req), 32'(s.req));
      if (s.req)
        chk(mem_addr == s.addr, s_rot ? "R7 R10 addr" : "R6 R10 addr", mem_addr, s.addr);
      chk(hsync_n == !o_hs, "R4 hsync", 32'(hsync_n), 32'(!o_hs));
      chk(vsync_n == !o_vs, "R4 vsync", 32'(vsync_n), 32'(!o_vs));
      chk(pix_de == o_de, "R5 de", 32'(pix_de), 32'(o_de));
      chk({pix_r, pix_g, pix_b} == o_rgb, "R8 colour", 32'({pix_r, pix_g, pix_b}), 32'(o_rgb));
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); #1;
    reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); #1;
    reg_wen = 1'b0;
  endtask

  task automatic rd_chk(input logic [3:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); #1;
    reg_addr = a;
    #1;
    chk(reg_rdata == exp, tag, reg_rdata, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    idle(4);
    #1;
    // R1 reset state
    chk(pix_de == 1'b0, "R1 de", 32'(pix_de), 32'd0);
    chk({pix_r, pix_g, pix_b} == 24'd0, "R1 colour", 32'({pix_r, pix_g, pix_b}), 32'd0);
    chk(hsync_n && vsync_n, "R1 syncs", 32'({hsync_n, vsync_n}), 32'd3);
    chk(mem_req == 1'b0, "R1 fetch", 32'(mem_req), 32'd0);
    reg_addr = 4'd0; #1;
    chk(reg_rdata == 32'd0, "R1 base", reg_rdata, 32'd0);
    reg_addr = 4'd4; #1;
    chk(reg_rdata == 32'd0, "R1 ctrl", reg_rdata, 32'd0);
    @(negedge clk); #1;
    rst_n = 1'b1;
    idle(FRAME / 2);
    rd_chk(4'd4, 32'd0, "R1 ctrl after release");
    // R2 masked base
    wr(4'd0, 32'h1234_5678);
    rd_chk(4'd0, 32'h1220_0000, "R2 base readback");
    // R3 enable mid-frame, R10 base lands at frame boundary
    wr(4'd4, 32'h0000_0001);
    rd_chk(4'd4, 32'd1, "R3 ctrl readback");
    idle(2 * FRAME + 7);
    // R7 rotation with other bits set in the write
    wr(4'd4, 32'hFFFF_FFF7);
    rd_chk(4'd4, 32'd3, "R3 ctrl masked");
    idle(2 * FRAME);
    // R10 base change mid-frame
    idle(HT + 3);
    wr(4'd0, 32'hABCD_EF01);
    rd_chk(4'd0, 32'hABC0_0000, "R2 R10 new base");
    idle(2 * FRAME);
    // R3 other offsets ignored
    wr(4'd8, 32'hFFFF_FFFF);
    wr(4'd1, 32'h0000_0000);
    rd_chk(4'd0, 32'hABC0_0000, "R3 base untouched");
    rd_chk(4'd4, 32'd3, "R3 ctrl untouched");
    // R9 disable inside the visible area
    while (!(mh == 3 && mv == 1)) @(negedge clk);
    wr(4'd4, 32'd0);
    idle(FRAME + 5);
    wr(4'd4, 32'd1);
    idle(2 * FRAME);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule